// File: doc/BRIEF.md
# Pseudorandom RAM Fill Engine

This block fills a 255-entry, 8-bit memory with a fixed pseudorandom sequence on command. A processor writes a control word. If bit 0 is set, the engine reloads its generator with the seed and begins emitting write beats. Each beat carries a memory address, starting at zero, and the generator value for that address. The first value written is the seed itself. Each later value follows the linear congruential rule next = (0x11 * current + 0x9D) mod 256, using unsigned arithmetic. The seed is 0xD7.

The write side is a valid/ready stream.
- The engine raises `wr_valid` while a fill is in progress.
- A beat is accepted on a rising clock edge where `wr_valid` and `wr_ready` are both high.
- While `wr_ready` is low, the engine holds the same address and data, and the generator does not advance.
- With `wr_ready` held high, one beat is accepted per clock.

After the beat at address 0xFE is accepted, the engine drops `wr_valid` and sets the done bit. The done bit is bit 0 of the status word. Any control write clears the done bit. A start request during a fill abandons the current fill and begins again from the seed at address 0.

Top module: `lcg_fill_engine`

## Requirements
- R1: While `rst_n` is low, and after it is released with no control write, `wr_valid` is 0 and `status_rdata` is 0x00.
- R2: A control write with bit 0 of `ctrl_wdata` set makes `wr_valid` 1, `wr_addr` 0x00 and `wr_data` 0xD7 from the next clock cycle.
- R3: Each accepted beat with data R is followed by a beat with data (0x11*R + 0x9D) mod 256. The first five beats carry D7, E4, C1, 6E, EB.
- R4: Addresses go up by one per accepted beat, from 0x00 to 0xFE. Exactly 255 beats are accepted per fill.
- R5: With `wr_ready` held high, one beat is accepted every clock. Done is set 255 cycles after the start write.
- R6: While `wr_valid` is 1 and `wr_ready` is 0, the next cycle still has `wr_valid` 1, with `wr_addr` and `wr_data` unchanged.
- R7: After the beat at address 0xFE is accepted, status bit 0 (done) reads 1 and `wr_valid` is 0. Both stay that way until the next control write.
- R8: Any control write clears done on the next cycle, even when bit 0 is 0. A write with bit 0 clear starts no fill.
- R9: A start write during a fill restarts the stream at address 0x00 with data 0xD7. This holds even if a beat is accepted in the same cycle.
- R10: Status bits 7 to 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word; bit 0 requests a fill |
| status_rdata | output | 8 | Status word; bit 0 is done |
| wr_valid | output | 1 | Write beat present |
| wr_ready | input | 1 | Memory accepts the beat |
| wr_addr | output | 8 | Memory address of the beat |
| wr_data | output | 8 | Generator value for that address |

## Verification
The bench builds the block with its default parameters:
- 255 entries;
- 8-bit data;
- multiplier 0x11, which selects the shift-and-add variant of the next-value logic;
- increment 0x9D;
- seed 0xD7.

With these defaults, a full fill fits in a few hundred cycles. The bench can therefore compare every one of the 255 values with its own model, both with `wr_ready` stalling every third cycle and with it held high. The same defaults make the last-address boundary at 0xFE, the done flag and a mid-fill restart observable within a short run.

// File: rtl/lcg_fill_pkg.sv
package lcg_fill_pkg;
  localparam int CTRL_START_BIT = 0;
  localparam int STAT_DONE_BIT  = 0;
  localparam int CSR_W          = 8;

  typedef enum logic [0:0] {
    FILL_IDLE = 1'b0,
    FILL_RUN  = 1'b1
  } fill_state_e;
endpackage

// File: rtl/lcg_step.sv
module lcg_step #(
  parameter int DATA_W = 8,
  parameter int MULT   = 17,
  parameter int INC    = 157
) (
  input  logic [DATA_W-1:0] cur_i,
  output logic [DATA_W-1:0] nxt_o
);
  localparam logic [DATA_W-1:0] MULT_V = MULT[DATA_W-1:0];
  localparam logic [DATA_W-1:0] INC_V  = INC[DATA_W-1:0];

  generate
    if (MULT == 17) begin : g_shift_add
      // 17*x keeps only the low bits: (x << 4) + x
      assign nxt_o = (cur_i << 4) + cur_i + INC_V;
    end else begin : g_mult
      assign nxt_o = cur_i * MULT_V + INC_V;
    end
  endgenerate
endmodule

// File: rtl/lcg_value_reg.sv
module lcg_value_reg #(
  parameter int DATA_W = 8,
  parameter int MULT   = 17,
  parameter int INC    = 157,
  parameter int SEED   = 215
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic              advance_i,
  output logic [DATA_W-1:0] value_o
);
  localparam logic [DATA_W-1:0] SEED_V = SEED[DATA_W-1:0];

  logic [DATA_W-1:0] nxt;

  lcg_step #(.DATA_W(DATA_W), .MULT(MULT), .INC(INC)) u_step (
    .cur_i (value_o),
    .nxt_o (nxt)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         value_o <= SEED_V;
    else if (load_i)    value_o <= SEED_V;
    else if (advance_i) value_o <= nxt;
  end
endmodule

// File: rtl/lcg_fill_seq.sv
module lcg_fill_seq
  import lcg_fill_pkg::*;
#(
  parameter int DEPTH = 255,
  parameter int AW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          ctrl_we_i,
  input  logic          xfer_i,
  output logic          filling_o,
  output logic [AW-1:0] addr_o,
  output logic          done_o,
  output logic          advance_o
);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  fill_state_e state_q;
  logic        last_beat;

  assign filling_o = (state_q == FILL_RUN);
  assign last_beat = filling_o && xfer_i && (addr_o == LAST_ADDR);
  assign advance_o = filling_o && xfer_i && !last_beat && !start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= FILL_IDLE;
      addr_o  <= '0;
    end else if (start_i) begin
      state_q <= FILL_RUN;
      addr_o  <= '0;
    end else if (last_beat) begin
      state_q <= FILL_IDLE;
    end else if (advance_o) begin
      addr_o  <= addr_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         done_o <= 1'b0;
    else if (ctrl_we_i) done_o <= 1'b0;
    else if (last_beat) done_o <= 1'b1;
  end
endmodule

// File: rtl/lcg_fill_engine.sv
module lcg_fill_engine
  import lcg_fill_pkg::*;
#(
  parameter int DEPTH  = 255,
  parameter int DATA_W = 8,
  parameter int MULT   = 17,
  parameter int INC    = 157,
  parameter int SEED   = 215,
  localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ctrl_we,
  input  logic [CSR_W-1:0]  ctrl_wdata,
  output logic [CSR_W-1:0]  status_rdata,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [AW-1:0]     wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  logic start, xfer, done, advance, filling;
  logic unused_ctrl_bits;

  assign start            = ctrl_we && ctrl_wdata[CTRL_START_BIT];
  assign unused_ctrl_bits = ^ctrl_wdata;
  assign xfer             = wr_valid && wr_ready;
  assign wr_valid         = filling;

  lcg_fill_seq #(.DEPTH(DEPTH), .AW(AW)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start),
    .ctrl_we_i (ctrl_we),
    .xfer_i    (xfer),
    .filling_o (filling),
    .addr_o    (wr_addr),
    .done_o    (done),
    .advance_o (advance)
  );

  lcg_value_reg #(.DATA_W(DATA_W), .MULT(MULT), .INC(INC), .SEED(SEED)) u_val (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (start),
    .advance_i (advance),
    .value_o   (wr_data)
  );

  always_comb begin
    status_rdata                = '0;
    status_rdata[STAT_DONE_BIT] = done;
  end
endmodule

// File: rtl/lcg_fill_engine_chk.sv
module lcg_fill_engine_chk #(
  parameter int DEPTH  = 255,
  parameter int DATA_W = 8,
  parameter int MULT   = 17,
  parameter int INC    = 157,
  parameter int SEED   = 215,
  parameter int AW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ctrl_we,
  input logic [7:0]        ctrl_wdata,
  input logic [7:0]        status_rdata,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [AW-1:0]     wr_addr,
  input logic [DATA_W-1:0] wr_data
);
  localparam logic [AW-1:0]     LAST_ADDR = AW'(DEPTH - 1);
  localparam logic [DATA_W-1:0] MULT_V    = MULT[DATA_W-1:0];
  localparam logic [DATA_W-1:0] INC_V     = INC[DATA_W-1:0];
  localparam logic [DATA_W-1:0] SEED_V    = SEED[DATA_W-1:0];

  logic [DATA_W-1:0] model_next;
  assign model_next = wr_data * MULT_V + INC_V;

  logic mid_beat, end_beat;
  assign mid_beat = wr_valid && wr_ready && !ctrl_we && (wr_addr != LAST_ADDR);
  assign end_beat = wr_valid && wr_ready && !ctrl_we && (wr_addr == LAST_ADDR);

  p_start_seed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctrl_we && ctrl_wdata[0]) |=> (wr_valid && wr_addr == '0 && wr_data == SEED_V));

  p_next_value_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mid_beat |=> (wr_data == $past(model_next)));

  p_addr_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mid_beat |=> (wr_valid && wr_addr == $past(wr_addr) + 1'b1));

  p_hold_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready && !ctrl_we) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data)));

  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    end_beat |=> (status_rdata[0] && !wr_valid));

  p_done_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    status_rdata[0] |-> !wr_valid);

  p_clear_on_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !status_rdata[0]);

  p_upper_zero_r10: assert property (@(posedge clk) disable iff (!rst_n)
    status_rdata[7:1] == 7'd0);
endmodule

bind lcg_fill_engine lcg_fill_engine_chk #(
  .DEPTH(DEPTH), .DATA_W(DATA_W), .MULT(MULT), .INC(INC), .SEED(SEED), .AW(AW)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .ctrl_we      (ctrl_we),
  .ctrl_wdata   (ctrl_wdata),
  .status_rdata (status_rdata),
  .wr_valid     (wr_valid),
  .wr_ready     (wr_ready),
  .wr_addr      (wr_addr),
  .wr_data      (wr_data)
);

// File: tb/lcg_fill_engine_tb.sv
module lcg_fill_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_ENTRIES  = 255;
  localparam logic [15:0] VEC [5] = '{16'h00D7, 16'h01E4, 16'h02C1, 16'h036E, 16'h04EB};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ctrl_we = 1'b0;
  logic [7:0] ctrl_wdata = 8'h00;
  logic [7:0] status_rdata;
  logic       wr_valid;
  logic       wr_ready = 1'b0;
  logic [7:0] wr_addr;
  logic [7:0] wr_data;

  int n_checks = 0;
  int n_errors = 0;

  lcg_fill_engine u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .status_rdata(status_rdata), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] ref_next(input logic [7:0] r);
    int t;
    t = 17 * int'(r) + 157;
    return 8'(t % 256);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ctrl_write(input logic [7:0] v);
    ctrl_we    = 1'b1;
    ctrl_wdata = v;
    @(negedge clk);
    ctrl_we    = 1'b0;
    ctrl_wdata = 8'h00;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    logic [7:0] exp_addr, exp_val, held_a, held_d;
    int cnt, cyc, mism, cycles;
    bit stalled;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!wr_valid, "R1 valid in reset", wr_valid, 0);
    chk(status_rdata == 8'h00, "R1 status in reset", status_rdata, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(!wr_valid && status_rdata == 8'h00, "R1 idle after reset",
        {status_rdata, 7'b0, wr_valid}, 0);

    // R2 R3 R5: vector table walk with ready held high
    wr_ready = 1'b1;
    ctrl_write(8'h01);
    for (int i = 0; i < 5; i++) begin
      chk(wr_valid && {wr_addr, wr_data} == VEC[i], "R2/R3/R5 table beat",
          {wr_addr, wr_data}, VEC[i]);
      @(negedge clk);
    end

    // R9: restart in the middle of a fill (beat also accepted this edge)
    ctrl_write(8'h01);
    chk(wr_valid && wr_addr == 8'h00 && wr_data == 8'hD7, "R9 restart",
        {wr_addr, wr_data}, 16'h00D7);

    // R3 R4 R6 R7: full fill with stalls every third cycle
    exp_addr = 8'h00; exp_val = 8'hD7; cnt = 0; cyc = 0; mism = 0;
    stalled = 1'b0; held_a = '0; held_d = '0;
    while (cnt < N_ENTRIES && cyc < 3000) begin
      if (stalled)
        chk(wr_valid && wr_addr == held_a && wr_data == held_d, "R6 hold under stall",
            {wr_addr, wr_data}, {held_a, held_d});
      wr_ready = (cyc % 3 != 2);
      if (!(wr_valid && wr_addr == exp_addr && wr_data == exp_val)) begin
        mism++;
        chk(1'b0, "R3/R4 beat value", {wr_addr, wr_data}, {exp_addr, exp_val});
      end
      stalled = !wr_ready;
      held_a = wr_addr; held_d = wr_data;
      if (wr_ready) begin
        if (cnt == N_ENTRIES - 1)
          chk(exp_addr == 8'hFE, "R4 last address", exp_addr, 8'hFE);
        cnt++;
        exp_addr = exp_addr + 8'd1;
        exp_val = ref_next(exp_val);
      end
      cyc++;
      @(negedge clk);
    end
    chk(cnt == N_ENTRIES && mism == 0, "R3/R4 full fill", cnt, N_ENTRIES);
    chk(status_rdata == 8'h01, "R7/R10 done status", status_rdata, 8'h01);
    chk(!wr_valid, "R7 valid low after fill", wr_valid, 0);
    repeat (3) @(negedge clk);
    chk(status_rdata == 8'h01 && !wr_valid, "R7 done held",
        {status_rdata, 7'b0, wr_valid}, 16'h0100);

    // R8: write with bit 0 clear clears done, starts nothing
    ctrl_write(8'h00);
    chk(status_rdata == 8'h00, "R8 done cleared", status_rdata, 0);
    chk(!wr_valid, "R8 no fill started", wr_valid, 0);

    // R5: one beat per clock; done after exactly 255 cycles
    wr_ready = 1'b1;
    ctrl_write(8'h01);
    cycles = 0;
    while (!status_rdata[0] && cycles < 1000) begin
      cycles++;
      @(negedge clk);
    end
    chk(cycles == N_ENTRIES, "R5 fill length in cycles", cycles, N_ENTRIES);

    // R8: write with other bits only clears done
    ctrl_write(8'hFE);
    chk(status_rdata == 8'h00 && !wr_valid, "R8 upper-bit write",
        {status_rdata, 7'b0, wr_valid}, 0);

    // R1: reset during a fill
    ctrl_write(8'h01);
    repeat (4) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(!wr_valid && status_rdata == 8'h00, "R1 reset mid-fill",
        {status_rdata, 7'b0, wr_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule